// File: doc/BRIEF.md
# Word-Wide NOR Flash Command Decoder with Status Polling

This block is the write-command front end of a word-wide NOR flash controller. Bus write cycles (address and data) pass through a state machine that accepts commands only after a two-write unlock preamble. It can program one word, erase one sector, erase the whole array, pause and continue an erase, and return to array reads. Program and erase run as timed embedded operations. During such an operation a read returns a status word instead of array contents. The status word carries an inverted copy of the data bit being written, a bit that alternates on every status read, a sector-selective alternating bit and a time-limit flag. A `ready` output shows when the block is free. The cell array is a small register file.

States and transitions. `ST_READ` is the idle array-read state. An AAh write to 555h leads to `ST_UNL1`. A 55h write to 2AAh then leads to `ST_UNL2`. Any other write in either unlock state returns to `ST_READ`. From `ST_UNL2`, A0h at 555h enters `ST_PGM_SETUP`, 80h at 555h enters `ST_ERS_SETUP`, and anything else returns to `ST_READ`. In `ST_PGM_SETUP` the next write supplies the address and data and launches `ST_PGM_BUSY`. After `ST_ERS_SETUP` the preamble is repeated (`ST_ERS_UNL1`, `ST_ERS_UNL2`). In `ST_ERS_UNL2`, 30h at any address launches a sector erase in `ST_ERS_BUSY`, 10h at 555h launches a chip erase, and anything else returns to `ST_READ`. Both busy states return to `ST_READ` on completion, or go to `ST_FAIL` when the time limit is reached. A B0h write in `ST_ERS_BUSY` enters `ST_ERS_SUSP`, and a 30h write there resumes the erase. An F0h write leaves `ST_FAIL` for `ST_READ`. Hardware reset returns to `ST_READ` from any state.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: Commands are accepted only after AAh written to address 555h and then 55h written to address 2AAh (data compared on bits 7:0). A write that breaks the preamble or the setup sequence returns the decoder to array reads, and the later writes of that broken sequence have no effect on the array.
- R2: An F0h write returns the decoder to array reads. This holds in the middle of an unlock sequence and from the time-limit failure state.
- R3: A program operation stores the bitwise AND of the old word and the new data, so bits only go from 1 to 0.
- R4: `ready` falls on the clock edge that samples the final command write, stays low for exactly PGM_CYCLES cycles for a program, and then rises.
- R5: While a program is busy, a read returns a status word with bits 15:8 zero. Bit 7 is the inverse of bit 7 of the data being programmed. Bit 6 reads 0 on the first status read after launch and alternates on each further status read. Bits 5, 4, 3, 2, 1 and 0 are zero. After completion, reads return true array data.
- R6: Every write during a program operation is ignored. The operation length and the final array contents are unchanged, and no new command is started.
- R7: A sector erase sets every word of the addressed sector to all ones, leaves every other sector untouched, and keeps `ready` low for ERS_CYCLES active cycles. The sector is given by the top log2(SECTORS) bits of the word index.
- R8: A chip erase (10h at 555h after the erase preamble) sets every word of the array to all ones.
- R9: While an erase is busy, status bit 7 reads 0 and bit 6 alternates as in R5. Bit 2 reads 0 on the first read inside the erased region after launch and alternates only on reads inside that region. Reads outside the region show bit 2 as 0.
- R10: A B0h write during a busy erase suspends it. `ready` goes high and the busy timer freezes. A read inside the suspended sector returns bit 7 = 1, bit 6 = 0, and bit 2 alternating from its current value. A read outside that sector returns array data. A 30h write resumes the erase for the remaining cycles.
- R11: While `force_timeout` is high, a busy operation does not complete. LIMIT_CYCLES cycles after launch it enters the failure state. There `ready` stays low, status bit 5 reads 1, bits 7 and 6 behave as during the operation, and the array is not changed.
- R12: Hardware reset (`rst_n` low) stops a running operation at once. `ready` goes high, `rd_data` clears to zero and the target word keeps its old value.
- R13: `rd_data` is updated on the clock edge that samples `rd_en` and holds its value on every cycle without a read. After reset it reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Write data; command code in bits 7:0 |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | log2(WORDS) | Word index to read |
| rd_data | output | DW | Registered read result (array word or status word) |
| force_timeout | input | 1 | Test input that holds an operation from completing |
| ready | output | 1 | High when no program or erase is running |

## Verification
The bench builds the block with WORDS=16 and SECTORS=4, so each sector is four words and the sector boundaries are tested with a handful of addresses. PGM_CYCLES=12, ERS_CYCLES=30 and LIMIT_CYCLES=60 make it practical to count the busy window edge by edge. These values also let the bench show that suspend freezes the erase timer, and reach the time-limit failure within a few dozen cycles. Every status read is predicted bit by bit from the toggle history since launch and compared through a queue of expected read results.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_SETUP,
        ST_ERS_SETUP,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_PGM_BUSY,
        ST_ERS_BUSY,
        ST_ERS_SUSP,
        ST_FAIL
    } cmd_state_e;

    localparam logic [7:0]  OPC_UNLOCK_1    = 8'hAA;
    localparam logic [7:0]  OPC_UNLOCK_2    = 8'h55;
    localparam logic [7:0]  OPC_PROGRAM     = 8'hA0;
    localparam logic [7:0]  OPC_ERASE_SETUP = 8'h80;
    localparam logic [7:0]  OPC_SECTOR      = 8'h30;
    localparam logic [7:0]  OPC_CHIP        = 8'h10;
    localparam logic [7:0]  OPC_SUSPEND     = 8'hB0;
    localparam logic [7:0]  OPC_RESUME      = 8'h30;
    localparam logic [7:0]  OPC_RESET       = 8'hF0;

    localparam logic [10:0] UNLOCK_ADDR_1   = 11'h555;
    localparam logic [10:0] UNLOCK_ADDR_2   = 11'h2AA;

    // positions of the status flags inside a status word
    localparam int SB_POLL   = 7;
    localparam int SB_TOGGLE = 6;
    localparam int SB_LIMIT  = 5;
    localparam int SB_SECTOR = 2;

endpackage

// File: rtl/nor_op_timer.sv
module nor_op_timer #(
    parameter int PGM_CYCLES   = 100,
    parameter int ERS_CYCLES   = 1000,
    parameter int LIMIT_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    input  logic sel_erase,
    input  logic stall,
    output logic done,
    output logic expired
);
    localparam int CW = $clog2(LIMIT_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] target;

    assign target  = sel_erase ? CW'(ERS_CYCLES - 1) : CW'(PGM_CYCLES - 1);
    assign done    = run && !stall && (cnt_q == target);
    assign expired = run && (cnt_q == CW'(LIMIT_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (start)  cnt_q <= '0;
        else if (run)    cnt_q <= cnt_q + 1'b1;
    end

    // suspended or idle: the elapsed count must not move (R10)
    p_count_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(cnt_q));

endmodule

// File: rtl/nor_word_store.sv
module nor_word_store #(
    parameter int DW      = 16,
    parameter int WORDS   = 16,
    parameter int SECTORS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pgm_we,
    input  logic [$clog2(WORDS)-1:0]   pgm_idx,
    input  logic [DW-1:0]              pgm_data,
    input  logic                       ers_we,
    input  logic                       ers_all,
    input  logic [$clog2(SECTORS)-1:0] ers_sec,
    input  logic [$clog2(WORDS)-1:0]   rd_idx,
    output logic [DW-1:0]              rd_word
);
    localparam int IW  = $clog2(WORDS);
    localparam int WPS = WORDS / SECTORS;

    logic [DW-1:0] words [WORDS];
    logic [DW-1:0] cur_word;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [DW-1:0] word_q;
        logic          ers_hit;
        assign ers_hit = ers_we && (ers_all || ((w / WPS) == int'(ers_sec)));
        always_ff @(posedge clk) begin
            if (ers_hit)
                word_q <= '1;
            else if (pgm_we && (pgm_idx == IW'(w)))
                word_q <= word_q & pgm_data;
        end
        assign words[w] = word_q;
    end

    assign rd_word  = words[rd_idx];
    assign cur_word = words[pgm_idx];

    // a program step may only clear bits (R3)
    p_one_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_we && !ers_we) |=> ((words[$past(pgm_idx)] & ~$past(cur_word)) == '0));

endmodule

// File: rtl/nor_status_view.sv
module nor_status_view
    import nor_cmd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rd_en,
    input  logic          in_pgm,
    input  logic          in_ers,
    input  logic          in_susp,
    input  logic          in_fail,
    input  logic          fail_is_pgm,
    input  logic          in_sector,
    input  logic          poll_src,
    input  logic [DW-1:0] arr_word,
    output logic [DW-1:0] rd_data
);
    logic          tog_all_q;
    logic          tog_sec_q;
    logic          show_status;
    logic          erase_kind;
    logic          sec_flip;
    logic [DW-1:0] stat_word;
    logic [DW-1:0] view;

    assign erase_kind  = in_ers || (in_fail && !fail_is_pgm);
    assign show_status = in_pgm || in_ers || in_fail;
    assign sec_flip    = (erase_kind || in_susp) && in_sector;

    always_comb begin
        stat_word = '0;
        if (show_status) begin
            stat_word[SB_POLL]   = (in_pgm || (in_fail && fail_is_pgm)) ? ~poll_src : 1'b0;
            stat_word[SB_TOGGLE] = tog_all_q;
            stat_word[SB_LIMIT]  = in_fail;
            stat_word[SB_SECTOR] = (erase_kind && in_sector) ? tog_sec_q : 1'b0;
            view = stat_word;
        end else if (in_susp && in_sector) begin
            stat_word[SB_POLL]   = 1'b1;
            stat_word[SB_SECTOR] = tog_sec_q;
            view = stat_word;
        end else begin
            view = arr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_all_q <= 1'b0;
            tog_sec_q <= 1'b0;
            rd_data   <= '0;
        end else begin
            if (clr) begin
                tog_all_q <= 1'b0;
                tog_sec_q <= 1'b0;
            end else if (rd_en) begin
                if (show_status) tog_all_q <= ~tog_all_q;
                if (sec_flip)    tog_sec_q <= ~tog_sec_q;
            end
            if (rd_en) rd_data <= view;
        end
    end

    // the read port only moves when a read is sampled (R13)
    p_read_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
    import nor_cmd_pkg::*;
#(
    parameter int AW           = 11,
    parameter int DW           = 16,
    parameter int WORDS        = 16,
    parameter int SECTORS      = 4,
    parameter int PGM_CYCLES   = 100,
    parameter int ERS_CYCLES   = 1000,
    parameter int LIMIT_CYCLES = 5000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     rd_en,
    input  logic [$clog2(WORDS)-1:0] rd_addr,
    output logic [DW-1:0]            rd_data,
    input  logic                     force_timeout,
    output logic                     ready
);
    localparam int IW = $clog2(WORDS);
    localparam int SW = $clog2(SECTORS);

    cmd_state_e    state_q, state_d;
    logic          launch, latch_pgm, latch_ers, ers_all_d;
    logic [IW-1:0] pgm_idx_q;
    logic [DW-1:0] pgm_data_q;
    logic [SW-1:0] ers_sec_q;
    logic          ers_all_q, op_ers_q;
    logic          at_first, at_second;
    logic [7:0]    opc;
    logic          tmr_done, tmr_expired;
    logic          in_pgm, in_ers, in_susp, in_fail, in_sector;
    logic          pgm_commit, ers_commit;
    logic [DW-1:0] arr_word;

    assign at_first  = (wr_addr == AW'(UNLOCK_ADDR_1));
    assign at_second = (wr_addr == AW'(UNLOCK_ADDR_2));
    assign opc       = wr_data[7:0];

    // next-state decode
    always_comb begin
        state_d   = state_q;
        launch    = 1'b0;
        latch_pgm = 1'b0;
        latch_ers = 1'b0;
        ers_all_d = 1'b0;
        unique case (state_q)
            ST_READ:
                if (wr_en && at_first && opc == OPC_UNLOCK_1) state_d = ST_UNL1;
            ST_UNL1:
                if (wr_en) state_d = (at_second && opc == OPC_UNLOCK_2) ? ST_UNL2 : ST_READ;
            ST_UNL2:
                if (wr_en) begin
                    if (at_first && opc == OPC_PROGRAM)          state_d = ST_PGM_SETUP;
                    else if (at_first && opc == OPC_ERASE_SETUP) state_d = ST_ERS_SETUP;
                    else                                         state_d = ST_READ;
                end
            ST_PGM_SETUP:
                if (wr_en) begin
                    state_d   = ST_PGM_BUSY;
                    launch    = 1'b1;
                    latch_pgm = 1'b1;
                end
            ST_ERS_SETUP:
                if (wr_en) state_d = (at_first && opc == OPC_UNLOCK_1) ? ST_ERS_UNL1 : ST_READ;
            ST_ERS_UNL1:
                if (wr_en) state_d = (at_second && opc == OPC_UNLOCK_2) ? ST_ERS_UNL2 : ST_READ;
            ST_ERS_UNL2:
                if (wr_en) begin
                    if (opc == OPC_SECTOR) begin
                        state_d   = ST_ERS_BUSY;
                        launch    = 1'b1;
                        latch_ers = 1'b1;
                    end else if (at_first && opc == OPC_CHIP) begin
                        state_d   = ST_ERS_BUSY;
                        launch    = 1'b1;
                        latch_ers = 1'b1;
                        ers_all_d = 1'b1;
                    end else begin
                        state_d   = ST_READ;
                    end
                end
            ST_PGM_BUSY:
                if (tmr_expired)   state_d = ST_FAIL;
                else if (tmr_done) state_d = ST_READ;
            ST_ERS_BUSY:
                if (tmr_expired)                       state_d = ST_FAIL;
                else if (tmr_done)                     state_d = ST_READ;
                else if (wr_en && opc == OPC_SUSPEND)  state_d = ST_ERS_SUSP;
            ST_ERS_SUSP:
                if (wr_en && opc == OPC_RESUME) state_d = ST_ERS_BUSY;
            ST_FAIL:
                if (wr_en && opc == OPC_RESET) state_d = ST_READ;
            default:
                state_d = ST_READ;
        endcase
    end

    // state register and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_READ;
            pgm_idx_q  <= '0;
            pgm_data_q <= '0;
            ers_sec_q  <= '0;
            ers_all_q  <= 1'b0;
            op_ers_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (latch_pgm) begin
                pgm_idx_q  <= wr_addr[IW-1:0];
                pgm_data_q <= wr_data;
                op_ers_q   <= 1'b0;
            end
            if (latch_ers) begin
                ers_sec_q  <= wr_addr[IW-1 -: SW];
                ers_all_q  <= ers_all_d;
                op_ers_q   <= 1'b1;
            end
        end
    end

    // outputs of the state machine
    always_comb begin
        in_pgm     = (state_q == ST_PGM_BUSY);
        in_ers     = (state_q == ST_ERS_BUSY);
        in_susp    = (state_q == ST_ERS_SUSP);
        in_fail    = (state_q == ST_FAIL);
        ready      = !(in_pgm || in_ers || in_fail);
        pgm_commit = in_pgm && tmr_done;
        ers_commit = in_ers && tmr_done;
        in_sector  = ers_all_q || (rd_addr[IW-1 -: SW] == ers_sec_q);
    end

    nor_op_timer #(
        .PGM_CYCLES  (PGM_CYCLES),
        .ERS_CYCLES  (ERS_CYCLES),
        .LIMIT_CYCLES(LIMIT_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (launch),
        .run      (in_pgm || in_ers),
        .sel_erase(op_ers_q),
        .stall    (force_timeout),
        .done     (tmr_done),
        .expired  (tmr_expired)
    );

    nor_word_store #(
        .DW     (DW),
        .WORDS  (WORDS),
        .SECTORS(SECTORS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .pgm_we  (pgm_commit),
        .pgm_idx (pgm_idx_q),
        .pgm_data(pgm_data_q),
        .ers_we  (ers_commit),
        .ers_all (ers_all_q),
        .ers_sec (ers_sec_q),
        .rd_idx  (rd_addr),
        .rd_word (arr_word)
    );

    nor_status_view #(
        .DW(DW)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (launch),
        .rd_en      (rd_en),
        .in_pgm     (in_pgm),
        .in_ers     (in_ers),
        .in_susp    (in_susp),
        .in_fail    (in_fail),
        .fail_is_pgm(!op_ers_q),
        .in_sector  (in_sector),
        .poll_src   (pgm_data_q[SB_POLL]),
        .arr_word   (arr_word),
        .rd_data    (rd_data)
    );

    // busy can only begin on a sampled write (R4)
    p_busy_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(wr_en));

    // the first unlock step needs the first unlock address (R1)
    p_unlock_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNL1 && $past(state_q) == ST_READ) |-> ($past(wr_addr) == AW'(UNLOCK_ADDR_1)));

    // writes cannot pull a program out of its busy window (R6)
    p_prog_deaf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pgm && !tmr_done && !tmr_expired) |=> (state_q == ST_PGM_BUSY));

    // a suspend request frees the block on the next cycle (R10)
    p_suspend_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ers && !tmr_done && !tmr_expired && wr_en && opc == OPC_SUSPEND) |=> ready);

    // failure is entered only from a running operation (R11)
    p_fail_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fail && $past(state_q) != ST_FAIL) |->
            ($past(state_q) == ST_PGM_BUSY || $past(state_q) == ST_ERS_BUSY));

    // hardware reset leaves the block ready (R12)
    p_reset_ready_r12: assert property (@(posedge clk)
        !rst_n |=> ready);

endmodule

// File: tb/nor_cmd_ctrl_test.sv
`timescale 1ns/1ps
module nor_cmd_ctrl_test;
    localparam int AW = 11, DW = 16, WORDS = 16, SECTORS = 4;
    localparam int PGM = 12, ERS = 30, LIM = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [3:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          force_timeout = 1'b0;
    logic          ready;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    logic          pend = 1'b0;
    logic          done_flag = 1'b0;

    always #4 clk = ~clk;

    nor_cmd_ctrl #(
        .AW(AW), .DW(DW), .WORDS(WORDS), .SECTORS(SECTORS),
        .PGM_CYCLES(PGM), .ERS_CYCLES(ERS), .LIMIT_CYCLES(LIM)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .force_timeout(force_timeout), .ready(ready)
    );

    // monitor: compare each sampled read with the next expected item
    always @(posedge clk) pend <= rd_en;
    always @(negedge clk) begin
        if (pend) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s read with no expectation: actual %h expected none", "R13", rd_data);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s read: actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [DW-1:0] e, input string tag);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock();
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
    endtask

    task automatic program_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
        unlock();
        wr(11'h555, 16'h00A0);
        wr(a, d);
    endtask

    task automatic erase_preamble();
        unlock();
        wr(11'h555, 16'h0080);
        unlock();
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(DW'(ready), 16'h1, "R13 reset ready");
        chk(rd_data, 16'h0000, "R13 reset rd_data");

        // R8 chip erase from unknown contents
        erase_preamble();
        wr(11'h555, 16'h0010);
        chk(DW'(ready), 16'h0, "R8 busy after chip erase");
        rd(4'd9, 16'h0000, "R9 chip erase status");
        wait_ready();
        rd(4'd0, 16'hFFFF, "R8 word0");
        rd(4'd9, 16'hFFFF, "R8 word9");
        rd(4'd15, 16'hFFFF, "R8 word15");
        idle(3);
        chk(rd_data, 16'hFFFF, "R13 hold without read");

        // R4 R5 program with exact busy window
        program_word(11'd3, 16'h1234);
        chk(DW'(ready), 16'h0, "R4 busy at final write");
        rd(4'd3, 16'h0080, "R5 first status");
        rd(4'd3, 16'h00C0, "R5 second status");
        idle(PGM - 3);
        chk(DW'(ready), 16'h0, "R4 busy last cycle");
        idle(1);
        chk(DW'(ready), 16'h1, "R4 ready after window");
        rd(4'd3, 16'h1234, "R5 true data after");

        // R3 AND semantics
        program_word(11'd3, 16'hFF0F);
        wait_ready();
        rd(4'd3, 16'h1204, "R3 and of old and new");

        // R6 writes during program are ignored
        program_word(11'd5, 16'h00FF);
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h00F0);
        idle(PGM - 4);
        chk(DW'(ready), 16'h0, "R6 window unchanged");
        idle(1);
        chk(DW'(ready), 16'h1, "R6 completes on time");
        idle(2);
        chk(DW'(ready), 16'h1, "R6 no command started");
        rd(4'd5, 16'h00FF, "R6 programmed value");

        // R1 broken preamble
        wr(11'h555, 16'h00AA);
        wr(11'h2AB, 16'h0055);
        wr(11'h555, 16'h00A0);
        wr(11'd6, 16'h0000);
        chk(DW'(ready), 16'h1, "R1 no launch after broken unlock");
        rd(4'd6, 16'hFFFF, "R1 word untouched");

        // R2 reset command inside an unlock sequence
        unlock();
        wr(11'h555, 16'h00F0);
        wr(11'd6, 16'h0000);
        chk(DW'(ready), 16'h1, "R2 reset aborts sequence");
        rd(4'd6, 16'hFFFF, "R2 word untouched");

        // R7 R9 R10 sector erase with suspend
        erase_preamble();
        wr(11'd4, 16'h0030);
        rd(4'd4, 16'h0000, "R9 in-sector read one");
        rd(4'd6, 16'h0044, "R9 in-sector read two");
        rd(4'd0, 16'h0000, "R9 outside sector");
        wr(11'd0, 16'h00B0);
        chk(DW'(ready), 16'h1, "R10 ready while suspended");
        rd(4'd5, 16'h0080, "R10 suspended status one");
        rd(4'd7, 16'h0084, "R10 suspended status two");
        rd(4'd3, 16'h1204, "R10 outside sector data");
        wr(11'd0, 16'h0030);
        chk(DW'(ready), 16'h0, "R10 resumed busy");
        idle(ERS - 4 - 1);
        chk(DW'(ready), 16'h0, "R10 timer frozen");
        idle(1);
        chk(DW'(ready), 16'h1, "R7 erase done");
        rd(4'd4, 16'hFFFF, "R7 sector word4");
        rd(4'd5, 16'hFFFF, "R7 sector word5");
        rd(4'd3, 16'h1204, "R7 other sector kept");

        // R11 forced timeout and R2 exit
        force_timeout = 1'b1;
        program_word(11'd8, 16'h5A5A);
        rd(4'd8, 16'h0080, "R11 before limit");
        idle(LIM + 1);
        chk(DW'(ready), 16'h0, "R11 still busy in failure");
        rd(4'd8, 16'h00E0, "R11 limit flag one");
        rd(4'd8, 16'h00A0, "R11 limit flag two");
        force_timeout = 1'b0;
        wr(11'd0, 16'h00F0);
        chk(DW'(ready), 16'h1, "R2 reset leaves failure");
        rd(4'd8, 16'hFFFF, "R11 array unchanged");

        // R12 hardware reset mid-program
        program_word(11'd3, 16'h0000);
        idle(3);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        chk(DW'(ready), 16'h1, "R12 ready after reset");
        chk(rd_data, 16'h0000, "R12 read port cleared");
        rd(4'd3, 16'h1204, "R12 word kept");

        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R13 pending reads: actual %0d expected 0", exp_q.size());
        end
        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule